// File: doc/BRIEF.md
# Command Queue Consumer with Wrap-Bit Pointers

This block is the device side of a circular command ring kept in a small local store. Software places 16-byte commands (two 64-bit words) into ring slots and then publishes a new producer pointer. While the queue is enabled, the block takes commands from the head slot in order and decodes the opcode in the low byte of the first word. It reports each invalidation as a one-cycle pulse carrying its identifier, and it advances a consumer pointer that software polls. Software treats the ring as drained once the consumer pointer equals the producer pointer.

Both pointers carry one extra wrap bit above the slot index, so a full ring and an empty ring can be told apart. A barrier command retires only after every earlier invalidation has been acknowledged by the caches downstream. An opcode the block does not know halts consumption and raises a command-error flag. The consumer pointer then stays on the faulting slot until software clears the enable and repairs the slot. A base register keeps the ring address and an allocate hint, and it reports the ring size as a log2 entry count.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset the consumer and producer pointers are 0, empty is 1, full is 0, the error flag is 0 and no invalidation or barrier pulse is raised.
- R2: Pointers are LOG2_DEPTH+1 bits wide (5 by default) and count modulo 32. Empty is 1 exactly when all pointer bits are equal. Full is 1 exactly when the low 4 index bits are equal and the top wrap bit differs.
- R3: Commands are consumed only while the enable bit (bit 3 of the control write data) is set. While it is clear, the consumer pointer holds and no pulse is produced.
- R4: Commands are taken in order from slot cons[3:0]. Each retired command moves the consumer pointer forward by exactly 1 modulo 32, and draining stops when consumer equals producer.
- R5: Opcode 0x04 (first word bits 7:0) raises cfg_inv_o for one cycle, with cfg_range_o equal to bits 4:0 of the second word (0x1F meaning everything).
- R6: Opcode 0x11 raises asid_inv_o for one cycle, with asid_o equal to bits 63:48 of the first word.
- R7: Opcode 0x30 raises glob_inv_o for one cycle.
- R8: Opcode 0x46 (barrier) retires only when no invalidation is still waiting for its inv_ack_i. When it retires, sync_done_o pulses for one cycle. Each invalidation pulse adds one to the waiting count and each inv_ack_i cycle removes one; an ack while the count is zero is ignored.
- R9: Any other opcode sets cmd_err_o and stops consumption, and the consumer pointer stays on the faulting slot. Writing the control register with bit 3 clear clears cmd_err_o.
- R10: base_o returns bit 62 and bits 51:5 as last written, bits 4:0 as LOG2_DEPTH (4), and every other bit as 0.
- R11: At most one of the four result pulses is high in any cycle, and each lasts a single cycle.
- R12: At most 2^PEND_W-1 (7) invalidations wait for acknowledgement at once. Further invalidations stall at the head until an ack arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control write data; bit 3 enables consumption |
| base_we_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 64 | Base register write data |
| base_o | output | 64 | Base register readback with size field |
| prod_we_i | input | 1 | Producer pointer write strobe |
| prod_wdata_i | input | LOG2_DEPTH+1 | New producer pointer |
| prod_o | output | LOG2_DEPTH+1 | Producer pointer readback |
| cons_o | output | LOG2_DEPTH+1 | Consumer pointer readback |
| empty_o | output | 1 | Ring empty |
| full_o | output | 1 | Ring full |
| cmd_we_i | input | 1 | Ring slot write strobe |
| cmd_widx_i | input | LOG2_DEPTH | Ring slot written |
| cmd_wlo_i | input | 64 | First command word |
| cmd_whi_i | input | 64 | Second command word |
| inv_ack_i | input | 1 | One invalidation completed downstream |
| cfg_inv_o | output | 1 | Configuration invalidate pulse |
| cfg_range_o | output | 5 | Range of the configuration invalidate |
| asid_inv_o | output | 1 | Invalidate-by-ASID pulse |
| asid_o | output | ASID_W | ASID of the invalidate |
| glob_inv_o | output | 1 | Global translation invalidate pulse |
| sync_done_o | output | 1 | Barrier retired pulse |
| cmd_err_o | output | 1 | Unknown opcode halted the ring |

## Verification
The hardest state to reach from the ports is a barrier held at the head while invalidations are still unacknowledged. The same holds for the case where the waiting count has reached its limit and stops invalidations from issuing. The bench reaches both by holding inv_ack_i low, queueing invalidations ahead of a barrier or nine invalidations in a row, and then releasing the acks one cycle at a time. It watches the consumer pointer stop on the right slot and advance only when expected. Random batches of 1 to 16 commands go round the ring many times, which exercises the full case and every wrap of the pointers.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

   localparam logic [7:0] OP_CFG_ALL    = 8'h04;
   localparam logic [7:0] OP_INV_ASID   = 8'h11;
   localparam logic [7:0] OP_INV_GLOBAL = 8'h30;
   localparam logic [7:0] OP_BARRIER    = 8'h46;

   typedef struct packed {
      logic [63:0] w1;
      logic [63:0] w0;
   } cmd_t;

   typedef enum logic [2:0] {
      K_CFG, K_ASID, K_GLOBAL, K_BARRIER, K_BAD
   } kind_t;

   function automatic kind_t decode_op(input logic [7:0] op);
      case (op)
         OP_CFG_ALL:    return K_CFG;
         OP_INV_ASID:   return K_ASID;
         OP_INV_GLOBAL: return K_GLOBAL;
         OP_BARRIER:    return K_BARRIER;
         default:       return K_BAD;
      endcase
   endfunction

endpackage

// File: rtl/cmdq_store.sv
module cmdq_store
   import cmdq_pkg::*;
#(
   parameter int unsigned LOG2_DEPTH = 4
)(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  we_i,
   input  logic [LOG2_DEPTH-1:0] widx_i,
   input  cmd_t                  wcmd_i,
   input  logic [LOG2_DEPTH-1:0] ridx_i,
   output cmd_t                  rcmd_o
);
   localparam int unsigned DEPTH = 1 << LOG2_DEPTH;

   cmd_t slot_w [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      cmd_t slot_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            slot_q <= '0;
         else if (we_i && (widx_i == LOG2_DEPTH'(i)))
            slot_q <= wcmd_i;
      end
      assign slot_w[i] = slot_q;
   end

   assign rcmd_o = slot_w[ridx_i];

endmodule

// File: rtl/cmdq_ptrs.sv
module cmdq_ptrs #(
   parameter int unsigned LOG2_DEPTH = 4
)(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  prod_we_i,
   input  logic [LOG2_DEPTH:0]   prod_wdata_i,
   input  logic                  adv_i,
   output logic [LOG2_DEPTH:0]   prod_o,
   output logic [LOG2_DEPTH:0]   cons_o,
   output logic [LOG2_DEPTH-1:0] head_idx_o,
   output logic                  empty_o,
   output logic                  full_o
);
   localparam int unsigned PTR_W = LOG2_DEPTH + 1;
   localparam int unsigned WRAP  = LOG2_DEPTH;

   logic [PTR_W-1:0] prod_q, cons_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prod_q <= '0;
         cons_q <= '0;
      end else begin
         if (prod_we_i) prod_q <= prod_wdata_i;
         if (adv_i)     cons_q <= cons_q + PTR_W'(1);
      end
   end

   assign empty_o    = (prod_q == cons_q);
   assign full_o     = (prod_q[WRAP-1:0] == cons_q[WRAP-1:0]) &&
                       (prod_q[WRAP] != cons_q[WRAP]);
   assign prod_o     = prod_q;
   assign cons_o     = cons_q;
   assign head_idx_o = cons_q[WRAP-1:0];

   // R4
   no_pass_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_i |-> !empty_o);

   // R2
   flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(empty_o && full_o));

endmodule

// File: rtl/cmdq_exec.sv
module cmdq_exec
   import cmdq_pkg::*;
#(
   parameter int unsigned ASID_W = 16,
   parameter int unsigned PEND_W = 3
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              empty_i,
   input  cmd_t              cmd_i,
   input  logic              inv_ack_i,
   input  logic              err_clr_i,
   output logic              adv_o,
   output logic              cfg_inv_o,
   output logic [4:0]        cfg_range_o,
   output logic              asid_inv_o,
   output logic [ASID_W-1:0] asid_o,
   output logic              glob_inv_o,
   output logic              sync_done_o,
   output logic              err_o
);
   kind_t             kind;
   logic [PEND_W-1:0] pend_q;
   logic              pend_full, pend_zero, live;
   logic              issue, retire_bar, fault, ack_take;
   logic              cfg_q, asid_q, glob_q, bar_q, err_q;
   logic [4:0]        range_q;
   logic [ASID_W-1:0] asid_q_id;

   assign kind      = decode_op(cmd_i.w0[7:0]);
   assign pend_full = &pend_q;
   assign pend_zero = (pend_q == '0);
   assign live      = en_i && !empty_i && !err_q;
   assign ack_take  = inv_ack_i && !pend_zero;

   always_comb begin
      issue      = 1'b0;
      retire_bar = 1'b0;
      fault      = 1'b0;
      if (live) begin
         case (kind)
            K_CFG, K_ASID, K_GLOBAL: issue      = !pend_full;
            K_BARRIER:               retire_bar = pend_zero;
            default:                 fault      = 1'b1;
         endcase
      end
   end

   assign adv_o = issue || retire_bar;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q    <= '0;
         cfg_q     <= 1'b0;
         asid_q    <= 1'b0;
         glob_q    <= 1'b0;
         bar_q     <= 1'b0;
         err_q     <= 1'b0;
         range_q   <= '0;
         asid_q_id <= '0;
      end else begin
         pend_q <= pend_q + PEND_W'(issue) - PEND_W'(ack_take);
         cfg_q  <= issue && (kind == K_CFG);
         asid_q <= issue && (kind == K_ASID);
         glob_q <= issue && (kind == K_GLOBAL);
         bar_q  <= retire_bar;
         if (issue && (kind == K_CFG))  range_q   <= cmd_i.w1[4:0];
         if (issue && (kind == K_ASID)) asid_q_id <= cmd_i.w0[48 +: ASID_W];
         if (err_clr_i)  err_q <= 1'b0;
         else if (fault) err_q <= 1'b1;
      end
   end

   assign cfg_inv_o   = cfg_q;
   assign cfg_range_o = range_q;
   assign asid_inv_o  = asid_q;
   assign asid_o      = asid_q_id;
   assign glob_inv_o  = glob_q;
   assign sync_done_o = bar_q;
   assign err_o       = err_q;

   logic unused_bits;
   assign unused_bits = ^{cmd_i.w1[63:5], cmd_i.w0[47:8]};

   // R11
   one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({cfg_q, asid_q, glob_q, bar_q}));

   // R8
   barrier_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bar_q) |-> $past(pend_q == '0));

   // R9
   fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_q && !err_clr_i) |=> err_q);

   // R12
   pend_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_full && !ack_take) |=> pend_full);

endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
   import cmdq_pkg::*;
#(
   parameter int unsigned LOG2_DEPTH = 4,
   parameter int unsigned ASID_W     = 16,
   parameter int unsigned PEND_W     = 3,
   parameter int unsigned EN_BIT     = 3
)(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  ctrl_we_i,
   input  logic [31:0]           ctrl_wdata_i,
   input  logic                  base_we_i,
   input  logic [63:0]           base_wdata_i,
   output logic [63:0]           base_o,
   input  logic                  prod_we_i,
   input  logic [LOG2_DEPTH:0]   prod_wdata_i,
   output logic [LOG2_DEPTH:0]   prod_o,
   output logic [LOG2_DEPTH:0]   cons_o,
   output logic                  empty_o,
   output logic                  full_o,
   input  logic                  cmd_we_i,
   input  logic [LOG2_DEPTH-1:0] cmd_widx_i,
   input  logic [63:0]           cmd_wlo_i,
   input  logic [63:0]           cmd_whi_i,
   input  logic                  inv_ack_i,
   output logic                  cfg_inv_o,
   output logic [4:0]            cfg_range_o,
   output logic                  asid_inv_o,
   output logic [ASID_W-1:0]     asid_o,
   output logic                  glob_inv_o,
   output logic                  sync_done_o,
   output logic                  cmd_err_o
);
   localparam int unsigned PTR_W     = LOG2_DEPTH + 1;
   localparam logic [63:0] ADDR_MASK = ((64'h1 << 52) - 64'h1) & ~64'h1F;
   localparam logic [63:0] BASE_KEEP = (64'h1 << 62) | ADDR_MASK;
   localparam logic [63:0] SIZE_FLD  = 64'(LOG2_DEPTH);

   if (LOG2_DEPTH < 1 || LOG2_DEPTH > 10) begin : g_bad_depth
      $error("LOG2_DEPTH must lie in 1..10");
   end
   if (ASID_W < 1 || ASID_W > 16) begin : g_bad_asid
      $error("ASID_W must lie in 1..16");
   end
   if (PEND_W < 1 || PEND_W > 8) begin : g_bad_pend
      $error("PEND_W must lie in 1..8");
   end
   if (EN_BIT > 31) begin : g_bad_en
      $error("EN_BIT must address the 32-bit control word");
   end

   logic                  en_q;
   logic [63:0]           base_q;
   logic                  err_clr, adv;
   logic [LOG2_DEPTH-1:0] head_idx;
   logic [PTR_W-1:0]      cons_w;
   logic                  empty_w;
   cmd_t                  head_cmd, wr_cmd;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= 1'b0;
         base_q <= '0;
      end else begin
         if (ctrl_we_i) en_q   <= ctrl_wdata_i[EN_BIT];
         if (base_we_i) base_q <= base_wdata_i & BASE_KEEP;
      end
   end

   assign err_clr = ctrl_we_i && !ctrl_wdata_i[EN_BIT];
   assign base_o  = base_q | SIZE_FLD;
   assign wr_cmd  = '{w1: cmd_whi_i, w0: cmd_wlo_i};

   logic unused_ctrl;
   assign unused_ctrl = ^ctrl_wdata_i;

   cmdq_store #(.LOG2_DEPTH(LOG2_DEPTH)) u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cmd_we_i),
      .widx_i (cmd_widx_i),
      .wcmd_i (wr_cmd),
      .ridx_i (head_idx),
      .rcmd_o (head_cmd)
   );

   cmdq_ptrs #(.LOG2_DEPTH(LOG2_DEPTH)) u_ptrs (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .prod_we_i    (prod_we_i),
      .prod_wdata_i (prod_wdata_i),
      .adv_i        (adv),
      .prod_o       (prod_o),
      .cons_o       (cons_w),
      .head_idx_o   (head_idx),
      .empty_o      (empty_w),
      .full_o       (full_o)
   );

   cmdq_exec #(.ASID_W(ASID_W), .PEND_W(PEND_W)) u_exec (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en_q),
      .empty_i     (empty_w),
      .cmd_i       (head_cmd),
      .inv_ack_i   (inv_ack_i),
      .err_clr_i   (err_clr),
      .adv_o       (adv),
      .cfg_inv_o   (cfg_inv_o),
      .cfg_range_o (cfg_range_o),
      .asid_inv_o  (asid_inv_o),
      .asid_o      (asid_o),
      .glob_inv_o  (glob_inv_o),
      .sync_done_o (sync_done_o),
      .err_o       (cmd_err_o)
   );

   assign cons_o  = cons_w;
   assign empty_o = empty_w;

   // R3
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q |=> $stable(cons_w));

   // R9
   err_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_err_o |=> $stable(cons_w));

   // R4
   step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cons_w) |-> (cons_w == PTR_W'($past(cons_w) + PTR_W'(1))));

   // R10
   base_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      base_o[4:0] == 5'(LOG2_DEPTH));

endmodule

// File: tb/tb_cmdq_consumer.sv
module tb_cmdq_consumer;
   localparam int CLK_PERIOD = 10;
   localparam int NEV        = 8192;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic        base_we = 1'b0;
   logic [63:0] base_wdata = '0;
   logic [63:0] base_o;
   logic        prod_we = 1'b0;
   logic [4:0]  prod_wdata = '0;
   logic [4:0]  prod_o, cons_o;
   logic        empty_o, full_o;
   logic        cmd_we = 1'b0;
   logic [3:0]  cmd_widx = '0;
   logic [63:0] cmd_wlo = '0, cmd_whi = '0;
   logic        auto_ack = 1'b0, ack_pulse = 1'b0;
   logic        inv_ack;
   logic        cfg_inv_o, asid_inv_o, glob_inv_o, sync_done_o, cmd_err_o;
   logic [4:0]  cfg_range_o;
   logic [15:0] asid_o;

   assign inv_ack = auto_ack | ack_pulse;
   always #(CLK_PERIOD/2) clk = ~clk;

   cmdq_consumer dut (
      .clk_i(clk), .rst_ni(rst_n),
      .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
      .base_we_i(base_we), .base_wdata_i(base_wdata), .base_o(base_o),
      .prod_we_i(prod_we), .prod_wdata_i(prod_wdata), .prod_o(prod_o),
      .cons_o(cons_o), .empty_o(empty_o), .full_o(full_o),
      .cmd_we_i(cmd_we), .cmd_widx_i(cmd_widx), .cmd_wlo_i(cmd_wlo), .cmd_whi_i(cmd_whi),
      .inv_ack_i(inv_ack),
      .cfg_inv_o(cfg_inv_o), .cfg_range_o(cfg_range_o),
      .asid_inv_o(asid_inv_o), .asid_o(asid_o),
      .glob_inv_o(glob_inv_o), .sync_done_o(sync_done_o), .cmd_err_o(cmd_err_o)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // event kinds: 1 cfg, 2 asid, 3 global, 4 barrier
   int          ev_kind [NEV];
   logic [63:0] ev_val  [NEV];
   int          ev_n = 0;
   int          ex_kind [NEV];
   logic [63:0] ex_val  [NEV];
   int          ex_n = 0;
   int          ev_base = 0;

   always @(negedge clk) begin
      if (rst_n && ev_n < NEV - 4) begin
         if (cfg_inv_o)   begin ev_kind[ev_n] = 1; ev_val[ev_n] = 64'(cfg_range_o); ev_n++; end
         if (asid_inv_o)  begin ev_kind[ev_n] = 2; ev_val[ev_n] = 64'(asid_o);      ev_n++; end
         if (glob_inv_o)  begin ev_kind[ev_n] = 3; ev_val[ev_n] = 64'h0;            ev_n++; end
         if (sync_done_o) begin ev_kind[ev_n] = 4; ev_val[ev_n] = 64'h0;            ev_n++; end
      end
   end

   logic [4:0] sw_prod = '0;
   logic [4:0] sw_cons = '0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic string kind_tag(input int k);
      case (k)
         1: return "R5 cfg invalidate";
         2: return "R6 asid invalidate";
         3: return "R7 global invalidate";
         default: return "R8 barrier";
      endcase
   endfunction

   function automatic logic [7:0] kind_op(input int k);
      case (k)
         1: return 8'h04;
         2: return 8'h11;
         3: return 8'h30;
         4: return 8'h46;
         default: return 8'hA5;
      endcase
   endfunction

   function automatic logic [63:0] exp_value(input int k, input logic [63:0] w0, input logic [63:0] w1);
      case (k)
         1: return 64'(w1[4:0]);
         2: return 64'(w0[63:48]);
         default: return 64'h0;
      endcase
   endfunction

   function automatic bit exp_full(input logic [4:0] p, input logic [4:0] c);
      return (p[3:0] == c[3:0]) && (p[4] != c[4]);
   endfunction

   task automatic write_slot(input logic [3:0] idx, input logic [63:0] w0, input logic [63:0] w1);
      cmd_we = 1; cmd_widx = idx; cmd_wlo = w0; cmd_whi = w1;
      @(negedge clk);
      cmd_we = 0;
   endtask

   task automatic push_exp(input int k, input logic [63:0] v);
      ex_kind[ex_n] = k; ex_val[ex_n] = v; ex_n++;
   endtask

   task automatic put_cmd(input int k, input bit record);
      logic [63:0] w0, w1;
      w0 = {$urandom, $urandom};
      w1 = {$urandom, $urandom};
      w0[7:0] = kind_op(k);
      write_slot(sw_prod[3:0], w0, w1);
      if (record) push_exp(k, exp_value(k, w0, w1));
      sw_prod = sw_prod + 5'd1;
   endtask

   task automatic put_fixed(input int k, input logic [63:0] w0, input logic [63:0] w1);
      w0[7:0] = kind_op(k);
      write_slot(sw_prod[3:0], w0, w1);
      sw_prod = sw_prod + 5'd1;
   endtask

   task automatic publish();
      prod_we = 1; prod_wdata = sw_prod;
      @(negedge clk);
      prod_we = 0;
   endtask

   task automatic set_en(input bit b);
      ctrl_we = 1;
      ctrl_wdata = ($urandom & ~32'h8) | (b ? 32'h8 : 32'h0);
      @(negedge clk);
      ctrl_we = 0;
   endtask

   task automatic drain();
      for (int i = 0; i < 3000 && cons_o !== prod_o; i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic compare_events(input string tag);
      chk({tag, " R4 event count"}, 64'(ev_n - ev_base), 64'(ex_n));
      for (int i = 0; i < ex_n && (ev_base + i) < ev_n; i++) begin
         chk({kind_tag(ex_kind[i]), " kind"}, 64'(ev_kind[ev_base + i]), 64'(ex_kind[i]));
         chk({kind_tag(ex_kind[i]), " value"}, ev_val[ev_base + i], ex_val[i]);
      end
      ev_base = ev_n;
      ex_n = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] bv;
      logic [3:0]  bad_idx;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk("R1 cons", 64'(cons_o), 0);
      chk("R1 prod", 64'(prod_o), 0);
      chk("R1 empty", 64'(empty_o), 1);
      chk("R1 full", 64'(full_o), 0);
      chk("R1 err", 64'(cmd_err_o), 0);
      chk("R1 pulses", 64'({cfg_inv_o, asid_inv_o, glob_inv_o, sync_done_o}), 0);

      // R10 base register
      for (int i = 0; i < 3; i++) begin
         bv = (i == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : {$urandom, $urandom};
         base_we = 1; base_wdata = bv;
         @(negedge clk);
         base_we = 0;
         chk("R10 base readback", base_o,
             (bv & ((64'h1 << 62) | (((64'h1 << 52) - 64'h1) & ~64'h1F))) | 64'd4);
      end

      // R2 full ring with 16 commands
      auto_ack = 1;
      for (int i = 0; i < 16; i++) put_cmd(1 + ($urandom % 3), 1);
      publish();
      chk("R2 full at 16", 64'(full_o), 1);
      chk("R2 not empty at 16", 64'(empty_o), 0);
      set_en(1);
      drain();
      chk("R4 cons after full drain", 64'(cons_o), 64'(5'd16));
      chk("R2 empty after drain", 64'(empty_o), 1);
      chk("R2 not full after drain", 64'(full_o), 0);
      compare_events("full batch");
      set_en(0);
      sw_cons = sw_prod;

      // R3 disabled ring holds
      put_cmd(3, 1);
      put_cmd(2, 1);
      publish();
      repeat (10) @(negedge clk);
      chk("R3 cons held while disabled", 64'(cons_o), 64'(sw_cons));
      chk("R3 no pulses while disabled", 64'(ev_n - ev_base), 0);
      set_en(1);
      drain();
      compare_events("after enable");
      set_en(0);
      sw_cons = sw_prod;

      // R8 barrier waits for acks
      auto_ack = 0;
      put_fixed(1, 64'h0, 64'h1F);   push_exp(1, 64'h1F);
      put_fixed(2, 64'hBEEF_0000_0000_0000, 64'h0); push_exp(2, 64'hBEEF);
      put_fixed(4, 64'h0, 64'h0);    push_exp(4, 64'h0);
      publish();
      set_en(1);
      repeat (15) @(negedge clk);
      chk("R8 barrier held at head", 64'(cons_o), 64'(sw_cons + 5'd2));
      chk("R8 no barrier pulse yet", 64'(ev_n - ev_base), 2);
      ack_pulse = 1; @(negedge clk); ack_pulse = 0;
      repeat (5) @(negedge clk);
      chk("R8 barrier held with one ack left", 64'(cons_o), 64'(sw_cons + 5'd2));
      ack_pulse = 1; @(negedge clk); ack_pulse = 0;
      repeat (5) @(negedge clk);
      chk("R8 barrier retired", 64'(cons_o), 64'(sw_cons + 5'd3));
      compare_events("barrier");
      set_en(0);
      sw_cons = sw_prod;

      // R12 waiting-count cap
      for (int i = 0; i < 9; i++) put_cmd(3, 1);
      publish();
      set_en(1);
      repeat (20) @(negedge clk);
      chk("R12 stall after seven", 64'(cons_o), 64'(sw_cons + 5'd7));
      chk("R12 seven pulses", 64'(ev_n - ev_base), 7);
      auto_ack = 1;
      drain();
      compare_events("cap");
      set_en(0);
      sw_cons = sw_prod;

      // R9 unknown opcode
      put_cmd(3, 1);
      bad_idx = sw_prod[3:0];
      put_cmd(5, 0);
      put_fixed(2, 64'h1234_0000_0000_0000, 64'h0);
      publish();
      set_en(1);
      repeat (15) @(negedge clk);
      chk("R9 error raised", 64'(cmd_err_o), 1);
      chk("R9 cons on faulting slot", 64'(cons_o), 64'(sw_cons + 5'd1));
      chk("R9 only first pulse", 64'(ev_n - ev_base), 1);
      repeat (5) @(negedge clk);
      chk("R9 error holds", 64'(cmd_err_o), 1);
      set_en(0);
      chk("R9 error cleared", 64'(cmd_err_o), 0);
      write_slot(bad_idx, 64'h04, 64'h0A);
      push_exp(1, 64'h0A);
      push_exp(2, 64'h1234);
      set_en(1);
      drain();
      compare_events("error repair");
      set_en(0);
      sw_cons = sw_prod;

      // random batches, R2/R4/R5/R6/R7/R8
      for (int b = 0; b < 40; b++) begin
         int k;
         k = 1 + ($urandom % 16);
         if (b % 10 == 0) k = 16;
         for (int i = 0; i < k; i++) put_cmd(($urandom % 8 == 0) ? 4 : 1 + ($urandom % 3), 1);
         publish();
         chk("R2 random full flag", 64'(full_o), 64'(exp_full(sw_prod, sw_cons)));
         chk("R2 random empty flag", 64'(empty_o), 0);
         set_en(1);
         drain();
         chk("R4 random cons", 64'(cons_o), 64'(sw_prod));
         compare_events("random");
         set_en(0);
         sw_cons = sw_prod;
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule